// File: doc/BRIEF.md
# MIDI Serial Transceiver

This block is a single-channel asynchronous serial transmitter and receiver fixed to the MIDI line format. A free-running divider turns the system clock into a 500 kHz tick. Every serial bit lasts 16 of these ticks, which gives 31.25 kbit/s. A CPU uses a two-address register bus to work the block. Address 0 is the data register: a write loads the transmitter and a read returns the last received byte. Address 1 is the status register. A single level interrupt goes high when a received byte is waiting or when a transmitted frame has finished. The raw receive line is also passed straight through to a thru output, so other instruments can be chained.

The transmitter has four named states: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`. An accepted write moves it from `TX_IDLE` to `TX_START`. After 16 ticks it moves to `TX_DATA`. After the 8th data bit it moves to `TX_STOP`. After 16 ticks of stop bit it returns to `TX_IDLE` and raises the transmit-done pulse.

The receiver has the states `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`. On a tick where the synchronised line is low it moves from `RX_IDLE` to `RX_START`. At mid-start it moves to `RX_DATA`, or falls back to `RX_IDLE` if the line has gone high again. After the 8th sample it moves to `RX_STOP`. It returns to `RX_IDLE` at mid-stop and delivers the byte there.

Top module: `midi_uart`

## Requirements
- R1: The serial frame on `midi_tx` has 10 bits in this order: a start bit (0), then 8 data bits with the least significant bit first, then a stop bit (1). The line rests at 1 while idle.
- R2: `tick` is true on every TICK_DIV-th clock edge after reset. Each transmitted bit lasts exactly 16 ticks. `midi_tx` goes low on the clock edge that accepts the write.
- R3: A write to address 0 while the transmitter is idle starts a frame with that byte. A write while a frame is in progress is ignored and does not change the frame being sent.
- R4: When a frame ends, a transmit interrupt flag is set and drives `irq`. The next accepted write to address 0 clears the flag. Status bit 6 reads 1 whenever the transmitter is idle.
- R5: The receiver detects a start bit on a tick where the synchronised line is low. It checks the line again 8 ticks later. If the line is high at that check, the frame is dropped and no byte is delivered.
- R6: A fully received byte sets status bit 7 and raises `irq`. The byte can then be read at address 0.
- R7: A read of address 0 clears status bit 7 and status bit 1 (overrun). This also drops the receive part of `irq`.
- R8: Status bit 0 is the framing error bit. Each completed frame updates it: it is 1 if the stop bit was sampled low and 0 otherwise. A frame with a bad stop bit still delivers its byte.
- R9: If a byte completes while status bit 7 is still set, status bit 1 becomes 1 and the new byte replaces the old one.
- R10: `midi_thru` always equals `midi_rx`, with no delay.
- R11: After reset, `midi_tx` is 1, `irq` is 0 and the status register reads 8'h40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 0 has side effects |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| midi_rx | input | 1 | Serial receive line |
| midi_tx | output | 1 | Serial transmit line |
| midi_thru | output | 1 | Unbuffered copy of `midi_rx` |
| irq | output | 1 | Receive-ready or transmit-done interrupt, active high |

## Verification
The transmit line responds to an accepted write on the very next clock edge. After that, each bit boundary falls exactly 16 ticks later, and a tick lands every TICK_DIV edges counted from reset. A behavioural model in the bench follows the same count, and `midi_tx` is compared against it at each falling edge. The thru path has no delay, so it is compared on every clock as well. Receive results become due about nine and a half bit times after the start edge, because the stop bit is sampled at its middle. The bench therefore reads the status only after the whole frame plus a short margin. Clears caused by reads take effect on the next edge, so the bench samples them one cycle after the read.

// File: rtl/midi_pkg.sv
package midi_pkg;
    localparam int OVS = 16;
    localparam int OVS_W = $clog2(OVS);
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/midi_tick_gen.sv
module midi_tick_gen #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick || (TICK_DIV == 1));
endmodule

// File: rtl/midi_tx.sv
module midi_tx
    import midi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              txd,
    output logic              idle,
    output logic              done
);
    localparam logic [OVS_W-1:0] TLAST = OVS_W'(OVS - 1);
    localparam int BW = $clog2(DATA_W);

    tx_state_t         state_q;
    logic [OVS_W-1:0]  tcnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == TLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            if (state_q != TX_IDLE && tick) tcnt_q <= tcnt_q + 1'b1;
            unique case (state_q)
                TX_IDLE: if (load) begin
                    state_q <= TX_START;
                    sh_q    <= din;
                    tcnt_q  <= '0;
                    bit_q   <= '0;
                end
                TX_START: if (bit_end) state_q <= TX_DATA;
                TX_DATA: if (bit_end) begin
                    sh_q <= {1'b1, sh_q[DATA_W-1:1]};
                    if (bit_q == BW'(DATA_W - 1)) state_q <= TX_STOP;
                    else bit_q <= bit_q + 1'b1;
                end
                TX_STOP: if (bit_end) state_q <= TX_IDLE;
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        txd  = 1'b1;
        idle = 1'b0;
        done = 1'b0;
        unique case (state_q)
            TX_IDLE:  idle = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_STOP:  done = bit_end;
            default:  idle = 1'b1;
        endcase
    end

    p_start_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE && load) |=> (state_q == TX_START && tcnt_q == '0));
    p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != TX_IDLE && load && !tick) |=> $stable(sh_q));
endmodule

// File: rtl/midi_rx.sv
module midi_rx
    import midi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    output logic [DATA_W-1:0] byte_o,
    output logic              valid,
    output logic              stop_bad
);
    localparam logic [OVS_W-1:0] TLAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] TMID = OVS_W'(OVS / 2 - 1);
    localparam int BW = $clog2(DATA_W);

    rx_state_t         state_q;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [OVS_W-1:0]  tcnt_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
            unique case (state_q)
                RX_IDLE: begin
                    tcnt_q <= '0;
                    if (!rx_s) state_q <= RX_START;
                end
                RX_START: if (tcnt_q == TMID) begin
                    tcnt_q  <= '0;
                    bit_q   <= '0;
                    state_q <= rx_s ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (tcnt_q == TLAST) begin
                    sh_q <= {rx_s, sh_q[DATA_W-1:1]};
                    if (bit_q == BW'(DATA_W - 1)) state_q <= RX_STOP;
                    else bit_q <= bit_q + 1'b1;
                end
                RX_STOP: if (tcnt_q == TLAST) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_o   = sh_q;
        valid    = 1'b0;
        stop_bad = 1'b0;
        unique case (state_q)
            RX_STOP: begin
                valid    = tick && (tcnt_q == TLAST);
                stop_bad = !rx_s;
            end
            default: ;
        endcase
    end

    p_false_start_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_START && tick && tcnt_q == TMID && rx_s) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/midi_uart.sv
module midi_uart
    import midi_pkg::*;
#(
    parameter int TICK_DIV = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       midi_rx,
    output logic       midi_tx,
    output logic       midi_thru,
    output logic       irq
);
    logic              tick;
    logic              tx_load, tx_idle, tx_done;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_valid, rx_bad;
    logic              rd_data;
    logic [DATA_W-1:0] data_q;
    logic              ready_q, ovr_q, ferr_q, txirq_q;

    midi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    assign tx_load = bus_wr && !bus_addr;
    assign rd_data = bus_rd && !bus_addr;

    midi_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .din(bus_wdata),
        .txd(midi_tx), .idle(tx_idle), .done(tx_done)
    );

    midi_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(midi_rx),
        .byte_o(rx_byte), .valid(rx_valid), .stop_bad(rx_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            ferr_q  <= 1'b0;
            txirq_q <= 1'b0;
        end else begin
            if (rx_valid) begin
                data_q  <= rx_byte;
                ready_q <= 1'b1;
                ferr_q  <= rx_bad;
                if (ready_q && !rd_data) ovr_q <= 1'b1;
                else if (rd_data) ovr_q <= 1'b0;
            end else if (rd_data) begin
                ready_q <= 1'b0;
                ovr_q   <= 1'b0;
            end
            if (tx_done) txirq_q <= 1'b1;
            else if (tx_load && tx_idle) txirq_q <= 1'b0;
        end
    end

    assign bus_rdata = bus_addr ? {ready_q, tx_idle, 4'b0000, ovr_q, ferr_q} : data_q;
    assign irq       = ready_q || txirq_q;
    assign midi_thru = midi_rx;

    p_ready_set_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (ready_q && irq));
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_valid) |=> (!ready_q && !ovr_q));
    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ready_q && !rd_data) |=> ovr_q);
    p_txirq_r4: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> (irq && tx_idle));
endmodule

// File: tb/midi_uart_bench.sv
module midi_uart_bench;
    localparam int DIV = 4;
    localparam int BITC = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       midi_rx = 1'b1;
    logic       midi_tx, midi_thru, irq;

    int n_run = 0, n_fail = 0;
    int edge_n = 0;
    int m_bit = -1, m_tk = 0;
    logic [7:0] m_byte = 8'h00;
    logic       m_txirq = 1'b0;
    logic       live = 1'b0;

    always #10 clk = ~clk;

    midi_uart #(.TICK_DIV(DIV)) u_midi_uart (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .midi_rx(midi_rx), .midi_tx(midi_tx), .midi_thru(midi_thru), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural transmit model, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            edge_n = 0; m_bit = -1; m_tk = 0; m_txirq = 1'b0;
        end else begin
            automatic bit was_idle = (m_bit < 0);
            edge_n++;
            if (!was_idle && (edge_n % DIV == 0)) begin
                m_tk++;
                if (m_tk == 16) begin
                    m_tk = 0;
                    m_bit++;
                    if (m_bit == 10) begin m_bit = -1; m_txirq = 1'b1; end
                end
            end
            if (was_idle && bus_wr && !bus_addr) begin
                m_bit = 0; m_tk = 0; m_byte = bus_wdata; m_txirq = 1'b0;
            end
        end
    end

    function automatic logic exp_txd();
        if (m_bit < 0 || m_bit == 9) return 1'b1;
        if (m_bit == 0) return 1'b0;
        return m_byte[m_bit-1];
    endfunction

    // per-clock comparison of line outputs (R1, R2, R3, R10)
    always @(negedge clk) begin
        if (live) begin
            chk("R1/R2/R3 txd", int'(midi_tx), int'(exp_txd()));
            chk("R10 thru", int'(midi_thru), int'(midi_rx));
        end
    end

    task automatic wr_data(input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 1'b1;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv);
        logic [9:0] fr;
        fr = {stopv, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            midi_rx = fr[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk);
        midi_rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic idle_cycles(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bus_addr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        #1;
        chk("R11 txd", int'(midi_tx), 1);
        chk("R11 irq", int'(irq), 0);
        chk("R11 status", int'(bus_rdata), 8'h40);

        // R6 / R7: one clean byte
        send_rx(8'h5A, 1'b1);
        rd_reg(1'b1, v); chk("R6 status", int'(v), 8'hC0);
        chk("R6 irq", int'(irq), 1);
        rd_reg(1'b0, v); chk("R6 data", int'(v), 8'h5A);
        #1;
        chk("R7 irq cleared", int'(irq), 0);
        rd_reg(1'b1, v); chk("R7 status", int'(v), 8'h40);

        // R9: two bytes with no read between
        send_rx(8'h11, 1'b1);
        send_rx(8'hE7, 1'b1);
        rd_reg(1'b1, v); chk("R9 overrun", int'(v), 8'hC2);
        rd_reg(1'b0, v); chk("R9 newest", int'(v), 8'hE7);
        rd_reg(1'b1, v); chk("R7 overrun cleared", int'(v), 8'h40);

        // R8: stop bit low, then a good frame
        send_rx(8'h3C, 1'b0);
        idle_cycles(BITC);
        rd_reg(1'b1, v); chk("R8 ferr set", int'(v), 8'hC1);
        rd_reg(1'b0, v); chk("R8 data", int'(v), 8'h3C);
        send_rx(8'h81, 1'b1);
        rd_reg(1'b1, v); chk("R8 ferr cleared", int'(v), 8'hC0);
        rd_reg(1'b0, v);

        // R5: glitch shorter than half a bit
        @(negedge clk); midi_rx = 1'b0;
        idle_cycles(3 * DIV);
        midi_rx = 1'b1;
        idle_cycles(12 * BITC);
        rd_reg(1'b1, v); chk("R5 glitch rejected", int'(v), 8'h40);
        chk("R5 irq", int'(irq), 0);

        // R1-style transmit frames with a busy write (R3) and irq (R4)
        wr_data(8'hA5);
        idle_cycles(3 * BITC);
        wr_data(8'h3C);
        rd_reg(1'b1, v); chk("R4 busy status", int'(v), 8'h00);
        idle_cycles(8 * BITC);
        chk("R4 irq after frame", int'(irq), 1);
        rd_reg(1'b1, v); chk("R4 idle status", int'(v), 8'h40);
        wr_data(8'h01);
        #1;
        chk("R4 irq cleared", int'(irq), 0);
        idle_cycles(11 * BITC);
        chk("R4 irq second", int'(irq), 1);
        chk("R1 line idle", int'(midi_tx), 1);

        live = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule